// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block recovers characters from an asynchronous serial line. The line idles high. A falling edge may be a start bit, and the block confirms it by sampling the line at mid-bit. It then samples every data bit, the optional parity bit and the first stop bit at the centre of the bit. A one-cycle tick enable, pulsing at 16 times the bit rate, sets the timing. The character size (five to nine bits) and the parity mode are run-time inputs. They use the same encoding as the matching transmitter.

When the first stop bit has been sampled, the block places the character in a holding register, right-aligned. The frame-error flag and the parity-error flag are stored at the same moment. A full flag then shows that unread data is waiting. A one-cycle read strobe clears that flag. A second stop bit, if the transmitter sends one, is never checked. The block looks for the next start edge as soon as the first stop bit has been sampled, so frames sent back to back with one stop bit are received.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, rx_full_o, frame_err_o and parity_err_o are 0 and rx_data_o is all zeros.
- R2: A falling edge on the line starts a frame only if the line is still low at the 8th tick after the edge. A low pulse shorter than that produces no frame, and rx_full_o does not change.
- R3: Data bits are sampled at mid-bit, least significant bit first. char_size_i selects the width: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, 7 gives 9 bits, and the unused codes 4 to 6 give 8 bits. The character is right-aligned in rx_data_o and the unused upper bits are 0.
- R4: parity_mode_i[1] set means a parity bit follows the last data bit, and parity_mode_i[0] then selects odd (1) or even (0) parity. Codes 0 and 1 mean no parity bit.
- R5: parity_err_o is latched high when the received parity bit differs from the XOR of the data bits (inverted for odd parity). It is latched low otherwise, and whenever parity is disabled.
- R6: frame_err_o is latched high only when the first stop bit is sampled low. A second stop bit is never sampled.
- R7: Hunting for the next start edge begins right after the first stop bit is sampled, so a frame that follows a single stop bit with no idle gap is received correctly.
- R8: Completing a frame sets rx_full_o and loads data and both error flags together. A read_i pulse in a cycle with no completion clears rx_full_o. Data and flags hold until the next completion.
- R9: If a frame completes in the same cycle as read_i, the completion wins: rx_full_o stays 1 and the new character is presented.
- R10: A frame that completes while unread data is present overwrites the data and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sampling enable, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| char_size_i | input | 3 | Character size code |
| parity_mode_i | input | 2 | Parity mode code |
| read_i | input | 1 | Read strobe, clears full flag |
| rx_data_o | output | 9 | Received character, right-aligned |
| rx_full_o | output | 1 | Unread data present |
| frame_err_o | output | 1 | First stop bit was low |
| parity_err_o | output | 1 | Parity mismatch |

## Verification
The two functions that can collide in one cycle are the loading of a completed frame and a read that clears the full flag. The bench first measures the cycle in which a frame's data appears, counting from a tick-aligned start of that frame. It then repeats the same frame timing with the full flag already set and pulses read exactly on that edge. The check passes only if the full flag is still set and the new character is shown. A later plain read must then clear the flag.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  localparam int unsigned DATA_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // size code -> data bit count; unused codes fall back to 8
  function automatic logic [3:0] char_bits(input logic [2:0] code);
    case (code)
      3'd0:    char_bits = 4'd5;
      3'd1:    char_bits = 4'd6;
      3'd2:    char_bits = 4'd7;
      3'd3:    char_bits = 4'd8;
      3'd7:    char_bits = 4'd9;
      default: char_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/rx_ctrl.sv
`timescale 1ns/1ps
module rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [3:0] nbits_i,
  input  logic       par_en_i,
  output logic       go_o,
  output logic       data_smp_o,
  output logic       par_smp_o,
  output logic       stop_smp_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2;

  rx_state_e   st_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    bit_q;
  logic          prev_q;

  logic bit_end, mid_hit;
  assign bit_end = tick_i && (cnt_q == CW'(OVS - 1));
  assign mid_hit = tick_i && (cnt_q == CW'(MID - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= line_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (prev_q && !line_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
        end
        ST_START: begin
          if (mid_hit) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= line_i ? ST_IDLE : ST_DATA;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (tick_i) cnt_q <= cnt_q + 1'b1;
          if (bit_end) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == nbits_i - 4'd1) st_q <= par_en_i ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (tick_i) cnt_q <= cnt_q + 1'b1;
          if (bit_end) st_q <= ST_STOP;
        end
        ST_STOP: begin
          if (tick_i) cnt_q <= cnt_q + 1'b1;
          if (bit_end) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign go_o       = (st_q == ST_START) && mid_hit && !line_i;
  assign data_smp_o = (st_q == ST_DATA)  && bit_end;
  assign par_smp_o  = (st_q == ST_PAR)   && bit_end;
  assign stop_smp_o = (st_q == ST_STOP)  && bit_end;

  // R2: a start bit found high at mid-bit is dropped
  assert_glitch_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START && mid_hit && line_i) |=> (st_q == ST_IDLE));

  // R7: after the first stop sample, hunting resumes immediately
  assert_rehunt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_smp_o |=> (st_q == ST_IDLE));
endmodule

// File: rtl/rx_shift.sv
`timescale 1ns/1ps
module rx_shift
  import uart_rx_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          par_i,
  input  logic          line_i,
  input  logic [3:0]    nbits_i,
  output logic [DW-1:0] data_o,
  output logic          par_bit_o
);
  logic [DW-1:0] sh_q;
  logic          par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      if (clr_i)        sh_q <= '0;
      else if (shift_i) sh_q <= {line_i, sh_q[DW-1:1]};
      if (par_i)        par_q <= line_i;
    end
  end

  // bits enter at the top, LSB first; right-align by the unused width
  assign data_o    = sh_q >> (4'(DW) - nbits_i);
  assign par_bit_o = par_q;
endmodule

// File: rtl/rx_hold.sv
`timescale 1ns/1ps
module rx_hold #(
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          read_i,
  input  logic [DW-1:0] data_i,
  input  logic          fe_i,
  input  logic          pe_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          fe_o,
  output logic          pe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      fe_o   <= 1'b0;
      pe_o   <= 1'b0;
    end else if (load_i) begin
      data_o <= data_i;
      fe_o   <= fe_i;
      pe_o   <= pe_i;
      full_o <= 1'b1;
    end else if (read_i) begin
      full_o <= 1'b0;
    end
  end

  assert_load_sets_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_o);
  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !load_i) |=> !full_o);
  assert_load_beats_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && load_i) |=> (full_o && data_o == $past(data_i)));
  assert_hold_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(data_o) && $stable(fe_o) && $stable(pe_o)));
endmodule

// File: rtl/uart_frame_rx.sv
`timescale 1ns/1ps
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic [2:0]    char_size_i,
  input  logic [1:0]    parity_mode_i,
  input  logic          read_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  output logic          frame_err_o,
  output logic          parity_err_o
);
  logic [1:0]    sync_q;
  logic          line_s;
  logic [3:0]    nbits;
  logic          par_en, par_odd;
  logic          go, data_smp, par_smp, stop_smp;
  logic [DW-1:0] asm_data;
  logic          par_bit, pe_now, fe_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end
  assign line_s = sync_q[1];

  assign nbits   = char_bits(char_size_i);
  assign par_en  = parity_mode_i[1];
  assign par_odd = parity_mode_i[0];

  rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .line_i     (line_s),
    .nbits_i    (nbits),
    .par_en_i   (par_en),
    .go_o       (go),
    .data_smp_o (data_smp),
    .par_smp_o  (par_smp),
    .stop_smp_o (stop_smp)
  );

  rx_shift #(.DW(DW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (go),
    .shift_i   (data_smp),
    .par_i     (par_smp),
    .line_i    (line_s),
    .nbits_i   (nbits),
    .data_o    (asm_data),
    .par_bit_o (par_bit)
  );

  assign pe_now = par_en && (par_bit != ((^asm_data) ^ par_odd));
  assign fe_now = !line_s;

  rx_hold #(.DW(DW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stop_smp),
    .read_i (read_i),
    .data_i (asm_data),
    .fe_i   (fe_now),
    .pe_i   (pe_now),
    .data_o (rx_data_o),
    .full_o (rx_full_o),
    .fe_o   (frame_err_o),
    .pe_o   (parity_err_o)
  );

  assert_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_smp |=> ((rx_data_o >> $past(nbits)) == '0));
  assert_fe_first_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_smp |=> (frame_err_o == !$past(line_s)));
  assert_pe_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_smp && !par_en) |=> !parity_err_o);
endmodule

// File: tb/sim_uart_frame_rx.sv
`timescale 1ns/1ps
module sim_uart_frame_rx;
  localparam int BITCLK = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [2:0] char_size_i = 3'd3;
  logic [1:0] parity_mode_i = 2'd0;
  logic       read_i = 1'b0;
  logic [8:0] rx_data_o;
  logic       rx_full_o, frame_err_o, parity_err_o;
  logic [1:0] tph = 2'd0;
  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tph    <= tph + 2'd1;
    tick_i <= (tph == 2'd3);
  end

  uart_frame_rx u0 (
    .clk_i, .rst_ni, .tick_i, .rxd_i, .char_size_i, .parity_mode_i, .read_i,
    .rx_data_o, .rx_full_o, .frame_err_o, .parity_err_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [2:0] code);
    case (code)
      3'd0: return 5; 3'd1: return 6; 3'd2: return 7; 3'd3: return 8;
      3'd7: return 9; default: return 8;
    endcase
  endfunction

  function automatic logic [8:0] msk(input logic [8:0] d, input int nb);
    return d & ((9'h1 << nb) - 9'h1);
  endfunction

  task automatic hold_bits(input int n);
    repeat (n * BITCLK) @(negedge clk_i);
  endtask

  task automatic align();
    @(negedge clk_i);
    while (tph != 2'd0) @(negedge clk_i);
  endtask

  // drives a full frame starting at the current negedge
  task automatic frame(input logic [8:0] d, input int nb, input int pm,
                       input bit flip, input bit stop1, input int idle);
    logic [8:0] m;
    m = msk(d, nb);
    rxd_i = 1'b0; hold_bits(1);
    for (int i = 0; i < nb; i++) begin rxd_i = m[i]; hold_bits(1); end
    if (pm >= 2) begin
      rxd_i = (^m) ^ (pm == 3) ^ flip; hold_bits(1);
    end
    rxd_i = stop1; hold_bits(1);
    rxd_i = 1'b1;
    if (idle > 0) hold_bits(idle);
  endtask

  task automatic do_read();
    @(negedge clk_i) read_i = 1'b1;
    @(negedge clk_i) read_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 data", rx_data_o, 0);
    chk("R1 full", rx_full_o, 0);
    chk("R1 fe", frame_err_o, 0);
    chk("R1 pe", parity_err_o, 0);
  endtask

  task automatic t_basic();
    logic [8:0] pats [3] = '{9'h0A5, 9'h03C, 9'h0FF};
    char_size_i = 3'd3; parity_mode_i = 2'd0;
    foreach (pats[k]) begin
      align(); frame(pats[k], 8, 0, 0, 1, 1);
      chk("R3 8bit data", rx_data_o, pats[k]);
      chk("R8 full set", rx_full_o, 1);
      chk("R6 no fe", frame_err_o, 0);
      do_read();
      chk("R8 read clears", rx_full_o, 0);
    end
  endtask

  task automatic t_sizes();
    logic [2:0] codes [5] = '{3'd0, 3'd1, 3'd2, 3'd7, 3'd5};
    foreach (codes[k]) begin
      char_size_i = codes[k];
      align(); frame(9'h1B7, nb_of(codes[k]), 0, 0, 1, 1);
      chk($sformatf("R3 size code %0d", codes[k]), rx_data_o, msk(9'h1B7, nb_of(codes[k])));
      chk("R3 no fe", frame_err_o, 0);
      do_read();
    end
    char_size_i = 3'd3;
  endtask

  task automatic t_parity();
    parity_mode_i = 2'd2;
    align(); frame(9'h0B3, 8, 2, 0, 1, 1);
    chk("R4 even data", rx_data_o, 9'h0B3); chk("R5 even ok", parity_err_o, 0);
    chk("R4 even no fe", frame_err_o, 0);
    align(); frame(9'h0B3, 8, 2, 1, 1, 1);
    chk("R5 even bad", parity_err_o, 1);
    parity_mode_i = 2'd3;
    align(); frame(9'h041, 8, 3, 0, 1, 1);
    chk("R5 odd ok", parity_err_o, 0); chk("R4 odd data", rx_data_o, 9'h041);
    align(); frame(9'h041, 8, 3, 1, 1, 1);
    chk("R5 odd bad", parity_err_o, 1);
    parity_mode_i = 2'd1;
    align(); frame(9'h05A, 8, 0, 0, 1, 1);
    chk("R4 reserved no parity data", rx_data_o, 9'h05A);
    chk("R4 reserved no fe", frame_err_o, 0);
    chk("R5 reserved pe clear", parity_err_o, 0);
    parity_mode_i = 2'd0;
    do_read();
  endtask

  task automatic t_frame_err();
    align(); frame(9'h066, 8, 0, 0, 0, 2);
    chk("R6 fe on low stop", frame_err_o, 1);
    chk("R8 data with fe", rx_data_o, 9'h066);
    chk("R8 full with fe", rx_full_o, 1);
    do_read();
    chk("R8 fe held after read", frame_err_o, 1);
    align(); frame(9'h011, 8, 0, 0, 1, 1);
    chk("R8 fe cleared by new frame", frame_err_o, 0);
    do_read();
  endtask

  task automatic t_stop2();
    align(); frame(9'h0C3, 8, 0, 0, 1, 0);
    rxd_i = 1'b0;
    repeat (BITCLK / 2) @(negedge clk_i);
    chk("R6 second stop ignored fe", frame_err_o, 0);
    chk("R6 second stop data", rx_data_o, 9'h0C3);
    chk("R6 second stop full", rx_full_o, 1);
    repeat (BITCLK / 2) @(negedge clk_i);
    rxd_i = 1'b1; hold_bits(12);
    do_read();
  endtask

  task automatic t_glitch();
    chk("R2 pre", rx_full_o, 0);
    align();
    rxd_i = 1'b0; repeat (12) @(negedge clk_i);
    rxd_i = 1'b1; hold_bits(12);
    chk("R2 glitch no frame", rx_full_o, 0);
    align(); frame(9'h09C, 8, 0, 0, 1, 1);
    chk("R2 recover data", rx_data_o, 9'h09C);
    do_read();
  endtask

  task automatic t_b2b();
    align();
    frame(9'h0E1, 8, 0, 0, 1, 0);
    frame(9'h01E, 8, 0, 0, 1, 1);
    chk("R7 back-to-back data", rx_data_o, 9'h01E);
    chk("R7 back-to-back fe", frame_err_o, 0);
    chk("R7 back-to-back full", rx_full_o, 1);
    do_read();
  endtask

  task automatic t_collide();
    int n_chg;
    logic [8:0] old;
    align(); frame(9'h033, 8, 0, 0, 1, 1);
    chk("R9 setup full", rx_full_o, 1);
    old = rx_data_o;
    n_chg = 0;
    align();
    fork
      frame(9'h0CC, 8, 0, 0, 1, 1);
      begin
        do begin @(negedge clk_i); n_chg++; end while (rx_data_o == old && n_chg < 2000);
      end
    join
    chk("R9 calibration data", rx_data_o, 9'h0CC);
    old = rx_data_o;
    align();
    fork
      frame(9'h155, 8, 0, 0, 1, 1);
      begin
        repeat (n_chg - 1) @(negedge clk_i);
        read_i = 1'b1;
        @(negedge clk_i); read_i = 1'b0;
        chk("R9 full kept on collision", rx_full_o, 1);
        chk("R9 new data on collision", rx_data_o, 9'h055);
      end
    join
    do_read();
    chk("R8 read after collision clears", rx_full_o, 0);
  endtask

  task automatic t_overwrite();
    parity_mode_i = 2'd2;
    align(); frame(9'h0F0, 8, 2, 1, 1, 1);
    chk("R10 first pe", parity_err_o, 1);
    align(); frame(9'h00F, 8, 2, 0, 1, 1);
    chk("R10 overwrite data", rx_data_o, 9'h00F);
    chk("R10 overwrite pe", parity_err_o, 0);
    chk("R10 still full", rx_full_o, 1);
    parity_mode_i = 2'd0;
    do_read();
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    hold_bits(1);
    t_basic();
    t_sizes();
    t_parity();
    t_frame_err();
    t_stop2();
    t_glitch();
    t_b2b();
    t_collide();
    t_overwrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule